// File: doc/BRIEF.md
# Nibble-Serial Program Counter Stack with Row Refresh

This block keeps one 12-bit program counter for each of four stack levels. The four counters sit in a small row-organised store. An external stack index picks the level that is live. Each instruction cycle is divided into eight one-clock subcycles. An external one-hot strobe vector marks these subcycles, and each action takes effect on the clock edge that closes its subcycle.

Early in each cycle, one row named by a wrapping refresh counter is copied into a working register and then written back unchanged. The live row is then read into the same working register, and its value is published on the address output. The register is advanced by one, a 4-bit slice at a time, through a single 4-bit incrementer that passes a stored carry from slice to slice. While a slice is being processed, its old value is shown on a 4-bit bus. Finally the register is stored back into the live row.

A registered row-source select decides which counter addresses the store. It turns to the refresh counter at the edge that opens subcycle 1. It turns to the stack index at the edge that opens subcycle 3. Between those edges it keeps its last setting.

Top module: `pcr_pc_stack`

## Requirements
- R1: After reset the address output is 0, the nibble bus is 0 and every row holds 0.
- R2: Each complete eight-subcycle frame adds one to the row named by the stack index. The new value appears on the address output in the next frame that uses that row.
- R3: The increment carries across slices: a low slice of 0xF rolls the middle slice, and 0x0FF becomes 0x100.
- R4: The value 0xFFF becomes 0x000, and the final carry is dropped.
- R5: The nibble bus shows the old value of a slice while that slice is processed. Bits 3:0 appear in subcycle 4, bits 7:4 in subcycle 5 and bits 11:8 in subcycle 6. In all other subcycles the bus is 0.
- R6: Rows not named by the stack index keep their values, including across refresh.
- R7: In subcycles 1 and 2 the row named by the refresh counter is rewritten with its own value. The refresh counter then steps by one, modulo four.
- R8: The row source is the refresh counter in subcycles 1 and 2, and the stack index from subcycle 3 through subcycle 0.
- R9: The address output loads the live row at the end of subcycle 3 and holds at every other edge.
- R10: The working register takes at most one of its three load sources in any cycle: refresh read, live-row read, or slice update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_strobe_i | input | 8 | One-hot subcycle marker; bit n is subcycle n |
| row_idx_i | input | 2 | Stack index of the live row |
| nib_bus_o | output | 4 | Slice currently fed to the incrementer |
| pc_o | output | 12 | Program counter value of the live row |

## Verification
Some properties are checked by assertions on every clock. These are the row-source setting in each subcycle, the unchanged rewrite during refresh, the refresh counter step, the exclusivity of the working-register load sources, and the hold of the address output. The remaining behaviours can only be shown by the bench's scenarios. These are the arithmetic results: the carries between slices, the wrap from 0xFFF to 0x000, and the independence of rows under a changing stack index. The bench checks them by driving a long run of frames against a behavioural model.

// File: rtl/pcr_pkg.sv
// Package: shared subcycle numbering and row-source encoding for the
// program counter stack. Assumes one subcycle per clock, strobed one-hot.
package pcr_pkg;

    // Subcycle numbers; each action lands on the edge closing its subcycle.
    localparam int SC_IDLE   = 0;
    localparam int SC_REF_RD = 1;
    localparam int SC_REF_WR = 2;
    localparam int SC_ACT_RD = 3;
    localparam int SC_NIB0   = 4;

    // Which counter addresses the row store.
    typedef enum logic {
        SRC_STACK   = 1'b0,
        SRC_REFRESH = 1'b1
    } row_src_e;

endpackage

// File: rtl/pcr_row_select.sv
// Row-source select: a registered choice between the refresh counter and
// the stack index. It also holds the refresh counter itself.
// Assumes to_ref_i and to_stack_i are never high together.
module pcr_row_select
    import pcr_pkg::*;
#(
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          to_ref_i,
    input  logic          to_stack_i,
    input  logic [RW-1:0] stack_idx_i,
    output row_src_e      src_o,
    output logic [RW-1:0] ref_idx_o,
    output logic [RW-1:0] row_addr_o
);

    row_src_e      src_q;
    logic [RW-1:0] ref_q;

    // Holds the last chosen source; switches only on the two edges that open
    // subcycle 1 and subcycle 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= SRC_STACK;
        else if (to_ref_i)
            src_q <= SRC_REFRESH;
        else if (to_stack_i)
            src_q <= SRC_STACK;
    end

    // Refresh counter steps once per refresh rewrite and wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
        else if (to_stack_i)
            ref_q <= ref_q + 1'b1;
    end

    // Row address taken from the registered select, so it is stable all cycle.
    always_comb begin
        row_addr_o = (src_q == SRC_REFRESH) ? ref_q : stack_idx_i;
    end

    assign src_o     = src_q;
    assign ref_idx_o = ref_q;

    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        to_stack_i |=> ref_q == $past(ref_q) + 1'b1); // R7

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !to_stack_i |=> $stable(ref_q)); // R7

endmodule

// File: rtl/pcr_row_store.sv
// Row store: NROWS registers of AW bits each, with one combinational read
// port and one write port that share a single address.
// Assumes the address is stable through any cycle in which a write is made.
module pcr_row_store #(
    parameter int AW    = 12,
    parameter int NROWS = 4,
    localparam int RW   = $clog2(NROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] addr_i,
    input  logic          we_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] rdata_o
);

    logic [AW-1:0] rows_q [NROWS];

    // Each row is a separate register that is written only when addressed.
    for (genvar r = 0; r < NROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)
                rows_q[r] <= '0;
            else if (we_i && addr_i == RW'(r))
                rows_q[r] <= wdata_i;
        end
    end

    // Read port: plain mux over the rows.
    always_comb begin
        rdata_o = rows_q[addr_i];
    end

endmodule

// File: rtl/pcr_nibble_inc.sv
// Slice incrementer: adds one (on the first slice) or the stored carry
// (on the later slices) to a NW-bit slice, and keeps the carry-out for the
// next slice. Assumes start_i is only high together with step_i.
module pcr_nibble_inc #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          step_i,
    input  logic [NW-1:0] nib_i,
    output logic [NW-1:0] sum_o
);

    logic          carry_q;
    logic          add_in;
    logic [NW:0]   full_sum;

    // The first slice adds one; later slices add the carry kept from before.
    always_comb begin
        add_in   = start_i ? 1'b1 : carry_q;
        full_sum = {1'b0, nib_i} + {{NW{1'b0}}, add_in};
        sum_o    = full_sum[NW-1:0];
    end

    // Keeps the carry-out of each processed slice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (step_i)
            carry_q <= full_sum[NW];
    end

    AST_START_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> step_i); // R2

endmodule

// File: rtl/pcr_pc_stack.sv
// Program counter stack top. It sequences refresh, the live-row read, the
// slice-by-slice increment and the write-back across the subcycle frame.
// Assumes sub_strobe_i is one-hot and that row_idx_i is stable through a frame.
module pcr_pc_stack
    import pcr_pkg::*;
#(
    parameter int AW    = 12,
    parameter int NW    = 4,
    parameter int NROWS = 4,
    localparam int NNIB = AW / NW,
    localparam int SC_WB = SC_NIB0 + NNIB,
    localparam int NSUB = SC_WB + 1,
    localparam int RW   = $clog2(NROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] sub_strobe_i,
    input  logic [RW-1:0]   row_idx_i,
    output logic [NW-1:0]   nib_bus_o,
    output logic [AW-1:0]   pc_o
);

    logic [NNIB-1:0] nib_en;
    logic            load_ref, load_act, load_nib;
    logic            row_we;
    logic [RW-1:0]   row_addr;
    logic [RW-1:0]   ref_idx;
    row_src_e        src;
    logic [AW-1:0]   rd_data;
    logic [AW-1:0]   work_q;
    logic [AW-1:0]   pc_q;
    logic [NW-1:0]   nib_cur;
    logic [NW-1:0]   nib_sum;

    // One enable per slice, taken from consecutive subcycles.
    for (genvar k = 0; k < NNIB; k++) begin : g_nib_en
        assign nib_en[k] = sub_strobe_i[SC_NIB0 + k];
    end

    assign load_ref = sub_strobe_i[SC_REF_RD];
    assign load_act = sub_strobe_i[SC_ACT_RD];
    assign load_nib = |nib_en;
    assign row_we   = sub_strobe_i[SC_REF_WR] | sub_strobe_i[SC_WB];

    pcr_row_select #(.RW(RW)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .to_ref_i    (sub_strobe_i[SC_IDLE]),
        .to_stack_i  (sub_strobe_i[SC_REF_WR]),
        .stack_idx_i (row_idx_i),
        .src_o       (src),
        .ref_idx_o   (ref_idx),
        .row_addr_o  (row_addr)
    );

    pcr_row_store #(.AW(AW), .NROWS(NROWS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (row_addr),
        .we_i    (row_we),
        .wdata_i (work_q),
        .rdata_o (rd_data)
    );

    // Puts the slice selected by the current subcycle on the shared bus.
    always_comb begin
        nib_cur = '0;
        for (int k = 0; k < NNIB; k++)
            if (nib_en[k])
                nib_cur = nib_cur | work_q[k*NW +: NW];
    end

    pcr_nibble_inc #(.NW(NW)) u_inc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (nib_en[0]),
        .step_i  (load_nib),
        .nib_i   (nib_cur),
        .sum_o   (nib_sum)
    );

    // Working register: loaded from a row read, or one slice at a time from
    // the incrementer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            work_q <= '0;
        else if (load_ref || load_act)
            work_q <= rd_data;
        else if (load_nib)
            for (int k = 0; k < NNIB; k++)
                if (nib_en[k])
                    work_q[k*NW +: NW] <= nib_sum;
    end

    // Address output: captures the live row when it is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (load_act)
            pc_q <= rd_data;
    end

    assign pc_o      = pc_q;
    assign nib_bus_o = nib_cur;

    AST_SRC_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_strobe_i[SC_REF_RD] || sub_strobe_i[SC_REF_WR]) |-> src == SRC_REFRESH); // R8

    AST_SRC_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_strobe_i[SC_ACT_RD] || load_nib) |-> src == SRC_STACK); // R8

    AST_REFRESH_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        sub_strobe_i[SC_REF_WR] |-> work_q == rd_data); // R7

    AST_REFRESH_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        sub_strobe_i[SC_REF_WR] |-> row_addr == ref_idx); // R7

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_ref, load_act, load_nib})); // R10

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_act |=> $stable(pc_o)); // R9

    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_nib |-> nib_bus_o == '0); // R5

endmodule

// File: tb/tb_pcr_pc_stack.sv
`timescale 1ns/1ps
// Bench: drives full subcycle frames and compares the bus and address output
// on every clock with a behavioural model of the four counters.
module tb_pcr_pc_stack;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sub_strobe = 8'h00;
    logic [1:0] row_idx = 2'd0;
    logic [3:0] nib_bus;
    logic [11:0] pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int model_rows [4];
    int exp_pc = 0;
    int last_row = 0;

    always #2 clk = ~clk;

    pcr_pc_stack dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sub_strobe_i (sub_strobe),
        .row_idx_i    (row_idx),
        .nib_bus_o    (nib_bus),
        .pc_o         (pc)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One frame of eight subcycles on row idx, checked every clock.
    task automatic run_frame(input int idx);
        string tag;
        for (int s = 0; s < 8; s++) begin
            sub_strobe = 8'(1 << s);
            row_idx    = 2'(idx);
            #0.5;
            if (s >= 4 && s <= 6)
                check("R5", int'(nib_bus), (model_rows[idx] >> (4*(s-4))) & 'hF);
            else
                check("R5", int'(nib_bus), 0);
            @(posedge clk);
            if (s == 3)
                exp_pc = model_rows[idx];
            if (s == 7)
                model_rows[idx] = (model_rows[idx] + 1) & 'hFFF;
            @(negedge clk);
            if (s != 3)                                  tag = "R9";
            else if (idx != last_row)                    tag = "R6";
            else if (exp_pc == 0 && model_rows[idx] == 1) tag = "R4";
            else if ((exp_pc & 'hF) == 0)                tag = "R3";
            else                                         tag = "R2";
            check(tag, int'(pc), exp_pc);
        end
        last_row = idx;
    endtask

    initial begin
        for (int r = 0; r < 4; r++) model_rows[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", int'(pc), 0);
        check("R1", int'(nib_bus), 0);
        // R1 / R6: a first frame on each row shows it came out of reset as 0.
        for (int r = 0; r < 4; r++) run_frame(r);
        // R2 / R3 / R4: one row through a full wrap, with refresh running.
        for (int n = 0; n < 4100; n++) run_frame(0);
        // R6 / R7: rows interleaved in a changing order keep their own counts.
        for (int n = 0; n < 200; n++) run_frame((n * 3 + n / 4) % 4);
        // R3: bring row 2 up to 0x0FF and across the middle-slice carry.
        while (model_rows[2] != 'h0FF) run_frame(2);
        run_frame(2);
        run_frame(2);
        check("R3", int'(pc), 'h100);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule